// File: doc/BRIEF.md
# Dual-Clock Word Synchronizer FIFO

This block carries complete data words from one clock domain into a second, unrelated clock domain without tearing them. The producer side offers a word with a valid qualifier and sees a full flag in its own clock. The consumer side always sees the oldest stored word and an empty flag in its own clock. A read request there acts as an acknowledge that drops that word and moves on to the next.

Each side has its own clock, reset and enable. Words sit in a small register memory that is written on the producer clock and read combinationally at the consumer's read address. Only the pointers cross between the clocks. Each pointer is carried in Gray code, so at most one bit changes per step, and each passes through a two-flop synchronizer in the receiving clock. The words themselves are never synchronized bit by bit, because skew between bits could mix old and new bits.

Top module: `xclk_word_fifo`

## Requirements
- R1: `ADDR_W` must be 2 or more, and the FIFO holds exactly 2^`ADDR_W` words. `wr_full` is low while fewer words are held and goes high once 2^`ADDR_W` words are held.
- R2: After both resets, `rd_empty` is 1 and `wr_full` is 0.
- R3: A word is stored only in a write-clock cycle where `wr_valid`=1 and `wr_en`=1. With `wr_en`=0 the offered word is not stored.
- R4: A word offered while `wr_full`=1 is dropped and the write pointer stays unchanged. After the FIFO is drained, no extra word appears.
- R5: While `rd_empty`=0, `rd_data` shows the oldest stored word. A read-clock cycle with `rd_pop`=1, `rd_en`=1 and `rd_empty`=0 removes it, so words leave in the order they were written.
- R6: `rd_pop` while `rd_empty`=1, or with `rd_en`=0, has no effect and leaves the read pointer unchanged.
- R7: After a word is stored in an empty FIFO, `rd_empty` falls by the third read-clock falling edge. After a pop from a full FIFO, `wr_full` falls by the third write-clock falling edge.
- R8: The pointers are one bit wider than the address and cross in Gray code, so each registered Gray pointer changes at most one bit per clock. Word order and values are kept across several wraps of the pointers while both sides run at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain reset, asynchronous, active high |
| wr_en | input | 1 | Write-domain enable; when low, every write-domain register holds its value |
| wr_valid | input | 1 | Qualifier: `wr_data` holds a word to insert |
| wr_data | input | DATA_W | Word to insert |
| wr_full | output | 1 | FIFO full, in the write domain |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain reset, asynchronous, active high |
| rd_en | input | 1 | Read-domain enable; when low, every read-domain register holds its value |
| rd_pop | input | 1 | Acknowledge: drop the word now shown |
| rd_data | output | DATA_W | Oldest stored word |
| rd_empty | output | 1 | FIFO empty, in the read domain |

## Verification
Some results are due in the same domain as their stimulus: `wr_full` and the head word after a pop change at the clock edge that accepts the stimulus. The bench reads these at the next falling edge of that clock. Results that cross between the clocks pass through two synchronizer flops in the receiving clock. They are due two receiving edges after the source edge, which means by the third falling edge of the receiving clock. The bench either counts those falling edges against that bound or waits four edges of each clock before it judges a flag or a word.

// File: rtl/xwf_pkg.sv
package xwf_pkg;
   localparam int unsigned MAX_PTR_W = 32;

   // binary to reflected Gray code
   function automatic logic [MAX_PTR_W-1:0] bin_to_gray(input logic [MAX_PTR_W-1:0] b);
      return b ^ (b >> 1);
   endfunction
endpackage

// File: rtl/xwf_gray_sync.sv
module xwf_gray_sync #(
   parameter int unsigned PTR_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [PTR_W-1:0] src_gray,
   output logic [PTR_W-1:0] dst_gray
);
   logic [PTR_W-1:0] stage1_q;
   logic [PTR_W-1:0] stage2_q;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         stage1_q <= '0;
         stage2_q <= '0;
      end else if (en) begin
         stage1_q <= src_gray;
         stage2_q <= stage1_q;
      end
   end

   assign dst_gray = stage2_q;
endmodule

// File: rtl/xwf_store.sv
module xwf_store #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/xwf_wr_side.sv
module xwf_wr_side
   import xwf_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              valid,
   input  logic [ADDR_W:0]   rgray_sync,
   output logic              push,
   output logic [ADDR_W-1:0] waddr,
   output logic [ADDR_W:0]   wgray,
   output logic              full
);
   localparam int unsigned PW = ADDR_W + 1;

   logic [PW-1:0] wbin_q, wbin_nxt, wgray_q;
   logic [PW-1:0] full_pat;

   // full: the other side is exactly one lap behind
   assign full_pat = {~rgray_sync[PW-1:PW-2], rgray_sync[PW-3:0]};
   assign full     = (wgray_q == full_pat);
   assign push     = en & valid & ~full;
   assign wbin_nxt = wbin_q + 1'b1;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         wbin_q  <= '0;
         wgray_q <= '0;
      end else if (push) begin
         wbin_q  <= wbin_nxt;
         wgray_q <= PW'(bin_to_gray(MAX_PTR_W'(wbin_nxt)));
      end
   end

   assign waddr = wbin_q[ADDR_W-1:0];
   assign wgray = wgray_q;

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
      (full && valid) |=> $stable(wgray_q));
   a_r3_gated_write: assert property (@(posedge clk) disable iff (rst)
      (!valid || !en) |=> $stable(wgray_q));
   a_r8_wgray_one_bit: assert property (@(posedge clk) disable iff (rst)
      $onehot0(wgray_q ^ $past(wgray_q)));
endmodule

// File: rtl/xwf_rd_side.sv
module xwf_rd_side
   import xwf_pkg::*;
#(
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic              pop,
   input  logic [ADDR_W:0]   wgray_sync,
   output logic [ADDR_W-1:0] raddr,
   output logic [ADDR_W:0]   rgray,
   output logic              empty
);
   localparam int unsigned PW = ADDR_W + 1;

   logic [PW-1:0] rbin_q, rbin_nxt, rgray_q;
   logic          take;

   assign empty    = (rgray_q == wgray_sync);
   assign take     = en & pop & ~empty;
   assign rbin_nxt = rbin_q + 1'b1;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         rbin_q  <= '0;
         rgray_q <= '0;
      end else if (take) begin
         rbin_q  <= rbin_nxt;
         rgray_q <= PW'(bin_to_gray(MAX_PTR_W'(rbin_nxt)));
      end
   end

   assign raddr = rbin_q[ADDR_W-1:0];
   assign rgray = rgray_q;

   a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
      (empty || !en) |=> $stable(rgray_q));
   a_r8_rgray_one_bit: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rgray_q ^ $past(rgray_q)));
endmodule

// File: rtl/xclk_word_fifo.sv
module xclk_word_fifo #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              wr_clk,
   input  logic              wr_rst,
   input  logic              wr_en,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_full,
   input  logic              rd_clk,
   input  logic              rd_rst,
   input  logic              rd_en,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_empty
);
   localparam int unsigned PW = ADDR_W + 1;

   // R1: the full/empty scheme needs two pointer bits above the address
   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("xclk_word_fifo: ADDR_W must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_data_w
         $error("xclk_word_fifo: DATA_W must be at least 1");
      end
   endgenerate

   logic              push;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [PW-1:0]     wgray, rgray, wgray_in_rd, rgray_in_wr;

   xwf_wr_side #(.ADDR_W(ADDR_W)) u_wr (
      .clk(wr_clk), .rst(wr_rst), .en(wr_en), .valid(wr_valid),
      .rgray_sync(rgray_in_wr), .push(push), .waddr(waddr),
      .wgray(wgray), .full(wr_full)
   );

   xwf_rd_side #(.ADDR_W(ADDR_W)) u_rd (
      .clk(rd_clk), .rst(rd_rst), .en(rd_en), .pop(rd_pop),
      .wgray_sync(wgray_in_rd), .raddr(raddr), .rgray(rgray),
      .empty(rd_empty)
   );

   xwf_gray_sync #(.PTR_W(PW)) u_w2r (
      .clk(rd_clk), .rst(rd_rst), .en(rd_en),
      .src_gray(wgray), .dst_gray(wgray_in_rd)
   );

   xwf_gray_sync #(.PTR_W(PW)) u_r2w (
      .clk(wr_clk), .rst(wr_rst), .en(wr_en),
      .src_gray(rgray), .dst_gray(rgray_in_wr)
   );

   xwf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .wclk(wr_clk), .we(push), .waddr(waddr), .wdata(wr_data),
      .raddr(raddr), .rdata(rd_data)
   );
endmodule

// File: tb/xclk_word_fifo_test.sv
`timescale 1ns/1ps
module xclk_word_fifo_test;
   localparam int DW    = 8;
   localparam int AW    = 3;
   localparam int DEPTH = 1 << AW;

   logic          wr_clk = 0, rd_clk = 0;
   logic          wr_rst = 1, rd_rst = 1;
   logic          wr_en = 1, rd_en = 1;
   logic          wr_valid = 0, rd_pop = 0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          wr_full, rd_empty;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 0;

   always #10 wr_clk = ~wr_clk;   // 50 MHz
   always #17 rd_clk = ~rd_clk;   // unrelated read clock

   xclk_word_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
      .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_valid(wr_valid),
      .wr_data(wr_data), .wr_full(wr_full),
      .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_pop(rd_pop),
      .rd_data(rd_data), .rd_empty(rd_empty)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic settle();
      repeat (4) @(negedge rd_clk);
      repeat (4) @(negedge wr_clk);
   endtask

   task automatic push_word(input logic [DW-1:0] d);
      @(negedge wr_clk);
      wr_valid = 1; wr_data = d;
      @(negedge wr_clk);
      wr_valid = 0;
   endtask

   task automatic pop_word(input logic [DW-1:0] exp, input string tag);
      @(negedge rd_clk);
      chk(rd_empty == 0, {tag, " not empty"}, rd_empty, 0);
      chk(rd_data == exp, {tag, " head word"}, rd_data, exp);
      rd_pop = 1;
      @(negedge rd_clk);
      rd_pop = 0;
   endtask

   task automatic t_reset();
      @(negedge wr_clk); wr_rst = 0;
      @(negedge rd_clk); rd_rst = 0;
      settle();
      chk(rd_empty == 1, "R2 empty after reset", rd_empty, 1);
      chk(wr_full == 0, "R2 full after reset", wr_full, 0);
   endtask

   task automatic t_fill_overflow();
      for (int i = 0; i < DEPTH; i++) begin
         chk(wr_full == 0, "R1 not full below capacity", wr_full, 0);
         push_word(DW'(8'h10 + i));
      end
      chk(wr_full == 1, "R1 full at capacity", wr_full, 1);
      push_word(8'hEE);   // dropped
      chk(wr_full == 1, "R4 full holds after dropped write", wr_full, 1);
      settle();
      for (int i = 0; i < DEPTH; i++) pop_word(DW'(8'h10 + i), "R4 R5 drain in order");
      settle();
      chk(rd_empty == 1, "R4 no extra word after drain", rd_empty, 1);
      chk(wr_full == 0, "R1 full clear after drain", wr_full, 0);
   endtask

   task automatic t_gating();
      wr_en = 0;
      push_word(8'h55);
      wr_en = 1;
      settle();
      chk(rd_empty == 1, "R3 write with enable low ignored", rd_empty, 1);
      push_word(8'h66);
      settle();
      @(negedge rd_clk);
      rd_en = 0; rd_pop = 1;
      @(negedge rd_clk);
      rd_pop = 0; rd_en = 1;
      settle();
      pop_word(8'h66, "R6 pop with enable low ignored");
      settle();
      chk(rd_empty == 1, "R5 empty after last pop", rd_empty, 1);
   endtask

   task automatic t_underflow();
      for (int k = 0; k < 3; k++) begin
         @(negedge rd_clk); rd_pop = 1;
         @(negedge rd_clk); rd_pop = 0;
      end
      chk(rd_empty == 1, "R6 still empty after pops", rd_empty, 1);
      push_word(8'h77);
      settle();
      pop_word(8'h77, "R6 read pointer not moved by empty pops");
      settle();
   endtask

   task automatic t_latency();
      int cnt;
      push_word(8'h3C);   // stored at the edge before push_word returns
      cnt = 1;
      while (rd_empty && cnt < 6) begin
         @(negedge rd_clk);
         if (rd_empty) cnt++;
      end
      chk(cnt <= 3, "R7 empty falls within 3 read edges", cnt, 3);
      pop_word(8'h3C, "R7 word after latency");
      settle();
      for (int i = 0; i < DEPTH; i++) push_word(DW'(8'hA0 + i));
      settle();
      chk(wr_full == 1, "R7 full before pop", wr_full, 1);
      @(negedge rd_clk); rd_pop = 1;
      @(posedge rd_clk); #1 rd_pop = 0;
      cnt = 0;
      while (wr_full && cnt < 6) begin
         @(negedge wr_clk);
         cnt++;
      end
      chk(cnt <= 3, "R7 full falls within 3 write edges", cnt, 3);
      settle();
      for (int i = 1; i < DEPTH; i++) pop_word(DW'(8'hA0 + i), "R7 remaining words");
      settle();
   endtask

   task automatic t_stream();
      localparam int N = 3 * DEPTH + 5;
      fork
         begin
            for (int i = 0; i < N; ) begin
               @(negedge wr_clk);
               if (!wr_full) begin
                  wr_valid = 1; wr_data = DW'(i * 7 + 3); i++;
               end else wr_valid = 0;
            end
            @(negedge wr_clk); wr_valid = 0;
         end
         begin
            for (int j = 0; j < N; ) begin
               @(negedge rd_clk);
               rd_pop = 0;
               if (!rd_empty) begin
                  chk(rd_data == DW'(j * 7 + 3), "R8 R5 streaming order", rd_data, DW'(j * 7 + 3));
                  rd_pop = 1; j++;
               end
            end
            @(negedge rd_clk); rd_pop = 0;
         end
      join
      settle();
      chk(rd_empty == 1, "R8 empty after stream", rd_empty, 1);
      chk(wr_full == 0, "R8 not full after stream", wr_full, 0);
   endtask

   initial begin
      t_reset();
      t_fill_overflow();
      t_gating();
      t_underflow();
      t_latency();
      t_stream();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         finished = 1;
         n_checks++; n_errors++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end
endmodule